// File: doc/BRIEF.md
# Write-Protect Key Sequencer

This block sits in front of the page-load engine of a byte-wide non-volatile memory. It looks at every write strobe (a 15-bit address with a byte of data) and decides whether that byte goes into the page buffer, is taken as part of a key, or is dropped. Two keys are recognised. A three-write key arms protection and also opens the current load for data. A six-write key disarms protection. Key bytes never reach the array.

Writes that come close enough together form one load period. The period closes when no write has arrived for `WIN_CYC` clock cycles. When it closes, the block asks the engine to start a timed programming cycle. It does this for every load period, even one where every byte was swallowed or refused, so a refused write still yields a busy period that stores nothing. The engine reports the end of the cycle. At that point a protect change set up by a key in the period takes effect.

The protect flag has no reset. It models storage that keeps its value through power loss and starts cleared.

Top module: `swp_gate`

## Requirements
- R1: After rst_ni is released, start_o, busy_o, pass_o and cmd_o are 0. protect_o is 0 from power-up.
- R2: While protect_o is 0, a write that is not a key byte gives pass_o=1 and cmd_o=0 in the same cycle as wr_valid_i.
- R3: The arm key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of these bytes gives cmd_o=1 and pass_o=0.
- R4: protect_o rises only on the clock edge where prog_done_i is sampled high while busy_o is high, and only after a load period that held the arm key. This is true even if no data byte followed the key.
- R5: While protect_o is 1, a write with no arm key earlier in its load period gives pass_o=0 and cmd_o=0. The load period still closes with start_o and busy_o, and protect_o stays 1.
- R6: While protect_o is 1, data bytes that follow the arm key in the same load period give pass_o=1.
- R7: The disarm key is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Each byte gives cmd_o=1. protect_o falls at the end of the programming cycle that follows. Until then, data writes stay refused.
- R8: A write that breaks a partly matched key is handled as an ordinary write, and matching starts again from the first key byte.
- R9: start_o is a one-cycle pulse, issued exactly WIN_CYC cycles after the last write of a load period. A gap of WIN_CYC-1 idle cycles keeps the period and any partial key. A gap of WIN_CYC idle cycles closes the period and drops the partial key.
- R10: busy_o rises with start_o and falls at the edge where prog_done_i is sampled. While busy_o is 1, writes give pass_o=0 and cmd_o=0 and open no load period.
- R11: Asserting rst_ni does not change protect_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 15 | Write address |
| wr_data_i | input | 8 | Write data |
| prog_done_i | input | 1 | Engine reports that the timed cycle has ended |
| pass_o | output | 1 | Current byte is to be loaded into the page buffer |
| cmd_o | output | 1 | Current byte was taken as a key byte |
| start_o | output | 1 | Pulse: start the timed programming cycle |
| busy_o | output | 1 | Programming cycle in progress |
| protect_o | output | 1 | Write protection is active |

## Verification
Data bytes are loaded with protection off and with protection on. This shows that protection gates only non-key bytes, and that a refused load still costs a busy period. Both full keys are applied, including an arm key with no data after it, to show that the flag changes only when the engine's cycle ends. Broken keys, and keys split by gaps of exactly WIN_CYC-1 and WIN_CYC idle cycles, separate a matcher that restarts correctly from one that carries stale progress. Writes during busy and a reset in the middle of the run check that neither can open a load period or clear the flag.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_P = 15'h5555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_Q = 15'h2AAA;
  localparam logic [DATA_W-1:0] KEY_LEAD   = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] KEY_ARM    = 8'hA0;
  localparam logic [DATA_W-1:0] KEY_EXT    = 8'h80;
  localparam logic [DATA_W-1:0] KEY_DISARM = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_K3   = 3'd3,
    ST_K4   = 3'd4,
    ST_K5   = 3'd5
  } key_st_e;
endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
  import swp_pkg::*;
(
  input  key_st_e            st_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               hit_o,
  output logic               arm_o,
  output logic               disarm_o,
  output key_st_e            nxt_o
);
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;
  logic              addr_ok;
  logic [2:0]        st_inc;

  always_comb begin
    exp_addr = (st_i == ST_K1 || st_i == ST_K4) ? KEY_ADDR_Q : KEY_ADDR_P;
    unique case (st_i)
      ST_K1, ST_K4: exp_data = KEY_SECOND;
      ST_K2:        exp_data = KEY_EXT;
      ST_K5:        exp_data = KEY_DISARM;
      default:      exp_data = KEY_LEAD;
    endcase
    addr_ok  = (addr_i == exp_addr);
    arm_o    = addr_ok && (st_i == ST_K2) && (data_i == KEY_ARM);
    hit_o    = arm_o || (addr_ok && data_i == exp_data);
    disarm_o = hit_o && (st_i == ST_K5);
    st_inc   = st_i + 3'd1;
    // a miss restarts matching; a finished key returns to idle
    if (!hit_o || arm_o || disarm_o) nxt_o = ST_IDLE;
    else                             nxt_o = key_st_e'(st_inc);
  end
endmodule

// File: rtl/swp_load_win.sv
module swp_load_win #(
  parameter int WIN_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o,
  output logic open_o
);
  localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic          sess_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = sess_q && !kick_i && (cnt_q == LAST);
  assign open_o   = sess_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q <= 1'b0;
      cnt_q  <= '0;
    end else if (kick_i) begin
      sess_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sess_q) begin
      if (cnt_q == LAST) begin
        sess_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sess_q |-> cnt_q == '0); // R9
endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
#(
  parameter int WIN_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [14:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prog_done_i,
  output logic              pass_o,
  output logic              cmd_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              protect_o
);
  key_st_e st_q, st_nxt;
  logic    hit, arm, disarm, acc, expire, win_open;
  logic    busy_q, start_q, unlk_q, pend_v_q, pend_val_q;
  logic    prot_q = 1'b0;  // non-volatile flag: no reset, clear when new

  assign acc = wr_valid_i && !busy_q;

  swp_key_match u_match (
    .st_i     (st_q),
    .addr_i   (wr_addr_i),
    .data_i   (wr_data_i),
    .hit_o    (hit),
    .arm_o    (arm),
    .disarm_o (disarm),
    .nxt_o    (st_nxt)
  );

  swp_load_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (acc),
    .expire_o (expire),
    .open_o   (win_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      unlk_q     <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_val_q <= 1'b0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= expire;
      if (acc) begin
        st_q <= st_nxt;
        if (arm) begin
          unlk_q     <= 1'b1;
          pend_v_q   <= 1'b1;
          pend_val_q <= 1'b1;
        end
        if (disarm) begin
          pend_v_q   <= 1'b1;
          pend_val_q <= 1'b0;
        end
      end else if (expire) begin
        st_q   <= ST_IDLE;
        unlk_q <= 1'b0;
      end
      if (expire) begin
        busy_q <= 1'b1;
      end else if (prog_done_i && busy_q) begin
        busy_q   <= 1'b0;
        pend_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (prog_done_i && busy_q && pend_v_q) prot_q <= pend_val_q;
  end

  assign cmd_o     = acc && hit;
  assign pass_o    = acc && !hit && (!prot_q || unlk_q);
  assign start_o   = start_q;
  assign busy_o    = busy_q;
  assign protect_o = prot_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R9
  AST_START_WITH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !pass_o && !cmd_o && !win_open); // R10
  AST_PROT_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o != $past(protect_o)) |-> $past(prog_done_i && busy_o)); // R4
endmodule

// File: tb/test_swp_gate.sv
module test_swp_gate;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0;
  logic [14:0] wa = '0;
  logic [7:0]  wd = '0;
  logic        pd = 1'b0;
  logic        pass, cmd, start, busy, prot;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  swp_gate #(.WIN_CYC(WIN)) i_swp_gate (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_addr_i(wa),
    .wr_data_i(wd), .prog_done_i(pd), .pass_o(pass), .cmd_o(cmd),
    .start_o(start), .busy_o(busy), .protect_o(prot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per clock
  int ka[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int kd[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};
  int m_step = 0, m_cnt = 0;
  bit m_unlk = 0, m_pv = 0, m_pval = 0, m_prot = 0;
  bit m_sess = 0, m_busy = 0, m_start = 0;

  always @(negedge clk) begin
    bit acc, hit, was_busy, nstart;
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_unlk = 0; m_pv = 0; m_pval = 0;
      m_sess = 0; m_busy = 0; m_start = 0;
    end
    acc = wv && !m_busy;
    hit = (int'(wa) == ka[m_step]) &&
          (int'(wd) == kd[m_step] || (m_step == 2 && wd == 8'hA0));
    chk("R2/R6 pass", pass, acc && !hit && (!m_prot || m_unlk));
    chk("R3/R7 cmd", cmd, acc && hit);
    chk("R9 start", start, m_start);
    chk("R10 busy", busy, m_busy);
    chk("R4 protect", prot, m_prot);
    if (rst_n) begin
      was_busy = m_busy;
      nstart = 0;
      if (acc) begin
        if (hit) begin
          if (m_step == 2 && wd == 8'hA0) begin
            m_unlk = 1; m_pv = 1; m_pval = 1; m_step = 0;
          end else if (m_step == 5) begin
            m_pv = 1; m_pval = 0; m_step = 0;
          end else m_step++;
        end else m_step = 0;
        m_sess = 1; m_cnt = 0;
      end else if (m_sess) begin
        if (m_cnt == WIN - 1) begin
          m_sess = 0; m_cnt = 0; m_step = 0; m_unlk = 0;
          m_busy = 1; nstart = 1;
        end else m_cnt++;
      end
      if (pd && was_busy) begin
        m_busy = 0;
        if (m_pv) m_prot = m_pval;
        m_pv = 0;
      end
      m_start = nstart;
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input logic ep, input logic ec, input string req);
    @(posedge clk); #2;
    wv = 1'b1; wa = a; wd = d;
    @(negedge clk); #1;
    chk({req, " pass"}, pass, ep);
    chk({req, " cmd"}, cmd, ec);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; wv = 1'b0;
    end
  endtask

  task automatic done();
    @(posedge clk); #2; wv = 1'b0; pd = 1'b1;
    @(posedge clk); #2; pd = 1'b0;
    @(negedge clk);
  endtask

  task automatic arm_key(input string req);
    wr(15'h5555, 8'hAA, 0, 1, req);
    wr(15'h2AAA, 8'h55, 0, 1, req);
    wr(15'h5555, 8'hA0, 0, 1, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 start", start, 0); chk("R1 protect", prot, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pass", pass, 0); chk("R1 cmd", cmd, 0);

    // unprotected data, exact window timing
    wr(15'h0010, 8'h3C, 1, 0, "R2");
    wr(15'h0011, 8'h5A, 1, 0, "R2");
    idle(WIN - 1);
    @(posedge clk); @(negedge clk); chk("R9 early", start, 0);
    @(posedge clk); @(negedge clk); chk("R9 on time", start, 1); chk("R10 rise", busy, 1);
    done();
    chk("R10 fall", busy, 0);

    // arm key with data
    arm_key("R3");
    wr(15'h0100, 8'h11, 1, 0, "R2");
    idle(WIN + 1);
    chk("R4 not yet", prot, 0);
    done();
    chk("R4 set", prot, 1);

    // refused write, then writes while busy
    wr(15'h0200, 8'h22, 0, 0, "R5");
    idle(WIN + 1);
    chk("R5 dummy busy", busy, 1);
    wr(15'h0300, 8'h33, 0, 0, "R10");
    wr(15'h5555, 8'hAA, 0, 0, "R10");
    idle(2);
    chk("R10 held", busy, 1);
    done();
    chk("R5 still", prot, 1);
    idle(WIN + 2);
    chk("R10 no session", busy, 0);

    // unlocked load while protected
    arm_key("R6");
    wr(15'h0400, 8'h44, 1, 0, "R6");
    wr(15'h0401, 8'h45, 1, 0, "R6");
    idle(WIN + 1); done();

    // broken key
    wr(15'h5555, 8'hAA, 0, 1, "R8");
    wr(15'h2AAA, 8'h55, 0, 1, "R8");
    wr(15'h1234, 8'h12, 0, 0, "R8");
    wr(15'h5555, 8'hA0, 0, 0, "R8");
    wr(15'h0500, 8'h55, 0, 0, "R8");
    idle(WIN + 1); done();

    // gap boundary keeps a partial key
    wr(15'h5555, 8'hAA, 0, 1, "R9");
    idle(WIN - 1);
    wr(15'h2AAA, 8'h55, 0, 1, "R9");
    idle(WIN - 1);
    wr(15'h5555, 8'hA0, 0, 1, "R9");
    wr(15'h0600, 8'h61, 1, 0, "R9");
    idle(WIN + 1); done();
    // full gap drops it
    wr(15'h5555, 8'hAA, 0, 1, "R9");
    wr(15'h2AAA, 8'h55, 0, 1, "R9");
    idle(WIN + 1);
    chk("R9 closed", busy, 1);
    done();
    wr(15'h5555, 8'hA0, 0, 0, "R9");
    idle(WIN + 1); done();

    // reset keeps the flag
    @(posedge clk); #2; rst_n = 1'b0;
    repeat (2) @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk("R11 protect", prot, 1); chk("R11 busy", busy, 0);

    // disarm key
    wr(15'h5555, 8'hAA, 0, 1, "R7");
    wr(15'h2AAA, 8'h55, 0, 1, "R7");
    wr(15'h5555, 8'h80, 0, 1, "R7");
    wr(15'h5555, 8'hAA, 0, 1, "R7");
    wr(15'h2AAA, 8'h55, 0, 1, "R7");
    wr(15'h5555, 8'h20, 0, 1, "R7");
    wr(15'h0700, 8'h70, 0, 0, "R7");
    idle(WIN + 1);
    chk("R7 until done", prot, 1);
    done();
    chk("R7 cleared", prot, 0);
    wr(15'h0701, 8'h71, 1, 0, "R7");
    idle(WIN + 1); done();

    // arm key with no data
    arm_key("R4");
    idle(WIN + 1); done();
    chk("R4 no data", prot, 1);

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule